// File: doc/BRIEF.md
# Peripheral Clock Gating and Divider Unit

This unit controls how clocks reach the peripherals of a chip and derives the slower processor, bus and slow-peripheral clocks from one fast base clock, taken here to be 96 MHz. Every clock leaving the unit is modelled as a single-cycle enable on the base clock. No real clock-tree cells are used.

Each peripheral has a sleep-permission bit. The bits are held in a bank of 32-bit words. A peripheral's clock enable drops only when two things are true. First, its permission bit is set, or a system-wide sleep-all bit is set. Second, the peripheral has withdrawn its own clock request. Software reaches the bank in two ways. A word-wide register port writes whole words. A single-bit port addresses one bit by word index and bit position, and rejects addresses that are out of range.

The processor clock is the base clock divided by a programmable value. A new value is adopted only at the end of the period in progress, so the unit never emits a shortened period. The bus clock runs at half the base rate. The slow clock runs at the bus rate divided by a programmable value, and a value of zero stops it. A heavy-sleep setting combined with sleep-all stops the processor and bus clocks.

Top module: `periph_clk_ctrl`

## Requirements
- R1: After reset, every permission word reads zero except word `CRYPTO_IDX`, which reads `CRYPTO_MASK`. The processor divider reads `CPU_DIV_RST`, the slow divider reads 0, the system control word reads 0, every peripheral enable is 1 and the bit-error flag is 0.
- R2: The register map is as follows. Addresses 0 to NUM_REGS-1 hold the permission words. Address NUM_REGS holds the processor divider, in bits [CPU_DIV_W-1:0]. Address NUM_REGS+1 holds the slow divider, in bits [SLOW_DIV_W-1:0]. Address NUM_REGS+2 holds the system control word: bit 0 is sleep-all and bit 1 is heavy. Bits outside these fields read 0, and an unmapped address reads 0.
- R3: A single-bit access with index < NUM_REGS and position < 32 writes `bit_val` into that one bit and leaves all other bits unchanged.
- R4: A single-bit access with index >= NUM_REGS or position >= 32 changes no bit. It raises `bit_err` for the one cycle after the request.
- R5: `periph_clk_en[i]` is 0 only when permission bit i or sleep-all is set and `clk_req[i]` is low. A change of `clk_req` reaches the enable on the third rising edge after it.
- R6: `cpu_clk_en` pulses once every D base cycles, where D is the processor divider. A write of 0 to the processor divider is ignored.
- R7: A new processor divider takes effect only after the period in progress has finished at the old length.
- R8: `slow_clk_en` pulses once every 2*S base cycles, where S is the slow divider. When S is 0 it never pulses.
- R9: A write to the slow divider restarts its count. The first pulse appears 2*S base cycles after the write edge.
- R10: `bus_clk_en` pulses every second base cycle.
- R11: When sleep-all and heavy are both set, `cpu_clk_en` and `bus_clk_en` stay 0. The slow clock and the peripheral enables are not affected. Either bit alone stops neither clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Word write strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | 32 | Word write data |
| reg_rdata | output | 32 | Word read data (combinational) |
| bit_req | input | 1 | Single-bit access strobe |
| bit_idx | input | 8 | Permission word index |
| bit_pos | input | 8 | Bit position in the word |
| bit_val | input | 1 | Value to write |
| bit_err | output | 1 | Rejected single-bit access |
| clk_req | input | NUM_REGS*32 | Per-peripheral clock requests |
| periph_clk_en | output | NUM_REGS*32 | Per-peripheral clock enables |
| cpu_clk_en | output | 1 | Processor clock enable |
| bus_clk_en | output | 1 | Bus clock enable |
| slow_clk_en | output | 1 | Slow peripheral clock enable |

## Verification
The bench builds the unit with four permission words, which gives 128 peripherals. It uses a protected mask of 0x6 in word 3, an 8-bit processor divider and a 10-bit slow divider. With four words, index 4 is the first rejected index, so the index rejection can be tested. An 8-bit position field can express 32, so the position rejection can be tested too. Divider values from 1 to 5 keep every period short enough to measure gaps between pulses, including the gap across an on-the-fly processor divider change and the gap after a slow divider rewrite.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

  typedef struct packed {
    logic heavy;
    logic all;
  } sysctl_t;

  function automatic logic bit_addr_ok(logic [7:0] idx, logic [7:0] pos,
                                       int unsigned nregs);
    return (32'(idx) < nregs) && (pos < 8'd32);
  endfunction

  function automatic logic stop_core(sysctl_t s);
    return s.all & s.heavy;
  endfunction

endpackage

// File: rtl/pcc_regbank.sv
module pcc_regbank
  import pcc_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int CRYPTO_IDX = 3,
  parameter logic [31:0] CRYPTO_MASK = 32'h0000_0006,
  parameter int CPU_DIV_W = 8,
  parameter int SLOW_DIV_W = 10,
  parameter int CPU_DIV_RST = 1,
  parameter int ADDR_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [31:0]               wdata,
  output logic [31:0]               rdata,
  input  logic                      bit_req,
  input  logic [7:0]                bit_idx,
  input  logic [7:0]                bit_pos,
  input  logic                      bit_val,
  output logic                      bit_err,
  output logic [NUM_REGS*32-1:0]    slp_flat,
  output logic [CPU_DIV_W-1:0]      cpu_div,
  output logic [SLOW_DIV_W-1:0]     slow_div,
  output logic                      slow_wr,
  output sysctl_t                   sysctl
);
  localparam logic [ADDR_W-1:0] CPU_ADDR  = ADDR_W'(NUM_REGS);
  localparam logic [ADDR_W-1:0] SLOW_ADDR = ADDR_W'(NUM_REGS + 1);
  localparam logic [ADDR_W-1:0] SYS_ADDR  = ADDR_W'(NUM_REGS + 2);

  logic [NUM_REGS-1:0][31:0] slp_q;
  logic bit_ok;
  logic cpu_wr;

  assign bit_ok   = bit_req && bit_addr_ok(bit_idx, bit_pos, NUM_REGS);
  assign cpu_wr   = wr_en && (addr == CPU_ADDR);
  assign slow_wr  = wr_en && (addr == SLOW_ADDR);
  assign slp_flat = slp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++)
        slp_q[i] <= (i == CRYPTO_IDX) ? CRYPTO_MASK : 32'h0;
      cpu_div  <= CPU_DIV_W'(CPU_DIV_RST);
      slow_div <= '0;
      sysctl   <= '0;
      bit_err  <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (wr_en && addr == ADDR_W'(i))
          slp_q[i] <= wdata;
        else if (bit_ok && 32'(bit_idx) == i)
          slp_q[i][bit_pos[4:0]] <= bit_val;
      end
      if (cpu_wr && wdata[CPU_DIV_W-1:0] != '0)
        cpu_div <= wdata[CPU_DIV_W-1:0];
      if (slow_wr)
        slow_div <= wdata[SLOW_DIV_W-1:0];
      if (wr_en && addr == SYS_ADDR)
        sysctl <= sysctl_t'(wdata[1:0]);
      bit_err <= bit_req && !bit_ok;
    end
  end

  always_comb begin
    rdata = 32'h0;
    for (int i = 0; i < NUM_REGS; i++)
      if (addr == ADDR_W'(i)) rdata = slp_q[i];
    if (addr == CPU_ADDR)  rdata = 32'(cpu_div);
    if (addr == SLOW_ADDR) rdata = 32'(slow_div);
    if (addr == SYS_ADDR)  rdata = {30'h0, sysctl};
  end

  // R4: a rejected bit access leaves the bank untouched and flags it
  p_bank_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_req && !bit_ok && !wr_en) |=> ($stable(slp_q) && bit_err));

  // R6: the processor divider never holds zero
  p_cpu_div_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_div != '0);

endmodule

// File: rtl/pcc_gate.sv
module pcc_gate #(
  parameter int NUM_PER = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_PER-1:0] req_in,
  input  logic [NUM_PER-1:0] slp_en,
  input  logic               sleep_all,
  output logic [NUM_PER-1:0] clk_en
);
  logic [NUM_PER-1:0] sync_q [SYNC_STAGES];
  logic [NUM_PER-1:0] eligible;

  assign eligible = slp_en | {NUM_PER{sleep_all}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '1;
      clk_en <= '1;
    end else begin
      sync_q[0] <= req_in;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
      clk_en <= ~(eligible & ~sync_q[SYNC_STAGES-1]);
    end
  end

  // R5: an enable only drops for a peripheral that was allowed to sleep
  p_gate_eligible_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (~clk_en & ~($past(slp_en) | {NUM_PER{$past(sleep_all)}})) == '0);

endmodule

// File: rtl/pcc_cpu_div.sv
module pcc_cpu_div #(
  parameter int W = 8,
  parameter int RST_DIV = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] div_req,
  output logic         tick
);
  logic [W-1:0] cnt;
  logic [W-1:0] cur;

  assign tick = (cnt == cur - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      cur <= W'(RST_DIV);
    end else if (tick) begin
      cnt <= '0;
      cur <= div_req;
    end else begin
      cnt <= cnt + W'(1);
    end
  end

  // R6: the count stays inside the active period
  p_cnt_in_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < cur);

  // R7: the active divider only changes at a period boundary
  p_switch_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur) |-> $past(tick));

endmodule

// File: rtl/pcc_slow_div.sv
module pcc_slow_div #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] div,
  input  logic         reload,
  output logic         tick
);
  logic [W:0] cnt;
  logic [W:0] period;

  assign period = {div, 1'b0};
  assign tick   = (div != '0) && (cnt == period - (W+1)'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (reload || div == '0)  cnt <= '0;
    else if (tick)                 cnt <= '0;
    else                           cnt <= cnt + (W+1)'(1);
  end

  // R9: a rewrite restarts the count
  p_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> cnt == '0);

  // R8: a stopped slow clock keeps its counter parked
  p_idle_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (div == '0 && !$past(reload)) |-> cnt == '0);

endmodule

// File: rtl/periph_clk_ctrl.sv
module periph_clk_ctrl
  import pcc_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int CRYPTO_IDX = 3,
  parameter logic [31:0] CRYPTO_MASK = 32'h0000_0006,
  parameter int CPU_DIV_W = 8,
  parameter int SLOW_DIV_W = 10,
  parameter int CPU_DIV_RST = 1,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W = 4,
  localparam int NUM_PER = NUM_REGS * 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               bit_req,
  input  logic [7:0]         bit_idx,
  input  logic [7:0]         bit_pos,
  input  logic               bit_val,
  output logic               bit_err,
  input  logic [NUM_PER-1:0] clk_req,
  output logic [NUM_PER-1:0] periph_clk_en,
  output logic               cpu_clk_en,
  output logic               bus_clk_en,
  output logic               slow_clk_en
);
  logic [NUM_PER-1:0]    slp_flat;
  logic [CPU_DIV_W-1:0]  cpu_div;
  logic [SLOW_DIV_W-1:0] slow_div;
  logic                  slow_wr;
  sysctl_t               sysctl;
  logic                  cpu_tick;
  logic                  bus_ph;
  logic                  core_stop;

  pcc_regbank #(
    .NUM_REGS(NUM_REGS), .CRYPTO_IDX(CRYPTO_IDX), .CRYPTO_MASK(CRYPTO_MASK),
    .CPU_DIV_W(CPU_DIV_W), .SLOW_DIV_W(SLOW_DIV_W),
    .CPU_DIV_RST(CPU_DIV_RST), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .bit_req(bit_req),
    .bit_idx(bit_idx), .bit_pos(bit_pos), .bit_val(bit_val),
    .bit_err(bit_err), .slp_flat(slp_flat), .cpu_div(cpu_div),
    .slow_div(slow_div), .slow_wr(slow_wr), .sysctl(sysctl)
  );

  pcc_gate #(.NUM_PER(NUM_PER), .SYNC_STAGES(SYNC_STAGES)) u_gate (
    .clk(clk), .rst_n(rst_n), .req_in(clk_req), .slp_en(slp_flat),
    .sleep_all(sysctl.all), .clk_en(periph_clk_en)
  );

  pcc_cpu_div #(.W(CPU_DIV_W), .RST_DIV(CPU_DIV_RST)) u_cpu (
    .clk(clk), .rst_n(rst_n), .div_req(cpu_div), .tick(cpu_tick)
  );

  pcc_slow_div #(.W(SLOW_DIV_W)) u_slow (
    .clk(clk), .rst_n(rst_n), .div(slow_div), .reload(slow_wr),
    .tick(slow_clk_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_ph <= 1'b0;
    else        bus_ph <= ~bus_ph;
  end

  assign core_stop  = stop_core(sysctl);
  assign cpu_clk_en = cpu_tick & ~core_stop;
  assign bus_clk_en = bus_ph & ~core_stop;

  // R10: bus enable never pulses on two consecutive cycles
  p_bus_alternate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_clk_en |=> !bus_clk_en);

endmodule

// File: tb/test_periph_clk_ctrl.sv
module test_periph_clk_ctrl;
  localparam int NREG = 4;
  localparam int NPER = NREG * 32;
  localparam logic [31:0] CMASK = 32'h0000_0006;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, bit_req = 0, bit_val = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [7:0] bit_idx = 0, bit_pos = 0;
  logic bit_err, cpu_clk_en, bus_clk_en, slow_clk_en;
  logic [NPER-1:0] clk_req = '1, periph_clk_en;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  periph_clk_ctrl #(.NUM_REGS(NREG), .CRYPTO_IDX(3), .CRYPTO_MASK(CMASK),
    .CPU_DIV_W(8), .SLOW_DIV_W(10), .CPU_DIV_RST(1)) i_periph_clk_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bit_req(bit_req),
    .bit_idx(bit_idx), .bit_pos(bit_pos), .bit_val(bit_val),
    .bit_err(bit_err), .clk_req(clk_req), .periph_clk_en(periph_clk_en),
    .cpu_clk_en(cpu_clk_en), .bus_clk_en(bus_clk_en),
    .slow_clk_en(slow_clk_en));

  localparam int NV = 8;
  localparam logic [3:0]  V_ADDR [NV] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7};
  localparam logic [31:0] V_DATA [NV] = '{32'hA5A5_5A5A, 32'hFFFF_0000, 32'h0000_0001,
    32'h1234_5678, 32'h0000_1207, 32'hFFFF_FB05, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
  localparam logic [31:0] V_EXP  [NV] = '{32'hA5A5_5A5A, 32'hFFFF_0000, 32'h0000_0001,
    32'h1234_5678, 32'h0000_0007, 32'h0000_0305, 32'h0000_0003, 32'h0000_0000};

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic bitop(logic [7:0] i, logic [7:0] p, logic v, output logic e);
    @(negedge clk); bit_req = 1; bit_idx = i; bit_pos = p; bit_val = v;
    @(posedge clk); @(negedge clk); bit_req = 0; e = bit_err;
  endtask

  function automatic logic sel_sig(int s);
    return (s == 0) ? cpu_clk_en : (s == 1) ? bus_clk_en : slow_clk_en;
  endfunction

  task automatic gap(int s, output int n);
    do @(negedge clk); while (!sel_sig(s));
    n = 0;
    do begin @(negedge clk); n++; end while (!sel_sig(s));
  endtask

  task automatic count(int s, int cyc, output int n);
    n = 0;
    repeat (cyc) begin @(negedge clk); if (sel_sig(s)) n++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic e;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < NREG; a++) begin
      rd(4'(a), d); chk("R1 sleep word", d, (a == 3) ? CMASK : 32'h0);
    end
    rd(4'd4, d); chk("R1 cpu div", d, 1);
    rd(4'd5, d); chk("R1 slow div", d, 0);
    rd(4'd6, d); chk("R1 sysctl", d, 0);
    chk("R1 periph enables", periph_clk_en, {NPER{1'b1}});
    chk("R1 bit_err", bit_err, 0);

    // R2 register map table
    for (int v = 0; v < NV; v++) begin
      wr(V_ADDR[v], V_DATA[v]);
      rd(V_ADDR[v], d);
      chk("R2 read back", d, V_EXP[v]);
    end
    for (int a = 0; a < NREG; a++) wr(4'(a), 0);
    wr(4'd6, 0); wr(4'd5, 0); wr(4'd4, 1);

    // R3 single-bit set/clear
    bitop(8'd2, 8'd31, 1'b1, e); chk("R3 no error", e, 0);
    rd(4'd2, d); chk("R3 bit set", d, 32'h8000_0000);
    bitop(8'd2, 8'd4, 1'b1, e); rd(4'd2, d); chk("R3 second bit", d, 32'h8000_0010);
    bitop(8'd2, 8'd31, 1'b0, e); rd(4'd2, d); chk("R3 bit clear", d, 32'h0000_0010);
    wr(4'd2, 0);

    // R4 rejected accesses
    bitop(8'd4, 8'd0, 1'b1, e); chk("R4 index error", e, 1);
    rd(4'd0, d); chk("R4 word0 untouched", d, 0);
    bitop(8'd1, 8'd32, 1'b1, e); chk("R4 position error", e, 1);
    rd(4'd1, d); chk("R4 word1 untouched", d, 0);
    @(negedge clk); chk("R4 error is one cycle", bit_err, 0);

    // R5 gating
    wr(4'd0, 32'h0000_0020);
    @(negedge clk); clk_req[5] = 0; clk_req[6] = 0;
    repeat (2) @(posedge clk); @(negedge clk);
    chk("R5 latency not yet", periph_clk_en[5], 1);
    @(posedge clk); @(negedge clk);
    chk("R5 gated when allowed and idle", periph_clk_en[5], 0);
    chk("R5 not allowed stays on", periph_clk_en[6], 1);
    @(negedge clk); clk_req[5] = 1;
    repeat (3) @(posedge clk); @(negedge clk);
    chk("R5 request restores", periph_clk_en[5], 1);
    @(negedge clk); clk_req = '0;
    wr(4'd6, 1);
    repeat (3) @(posedge clk); @(negedge clk);
    chk("R5 sleep-all gates idle", periph_clk_en, {NPER{1'b0}});
    @(negedge clk); clk_req = '1;
    repeat (3) @(posedge clk); @(negedge clk);
    chk("R5 all requesting", periph_clk_en, {NPER{1'b1}});
    wr(4'd6, 0); wr(4'd0, 0);

    // R6 processor divider
    gap(0, n); chk("R6 div1 gap", n, 1);
    wr(4'd4, 3); gap(0, n); gap(0, n); chk("R6 div3 gap", n, 3);
    wr(4'd4, 0); rd(4'd4, d); chk("R6 zero ignored", d, 3);
    gap(0, n); gap(0, n); chk("R6 div3 kept", n, 3);

    // R7 on-the-fly change
    wr(4'd4, 4); gap(0, n); gap(0, n); chk("R7 div4 gap", n, 4);
    do @(negedge clk); while (!cpu_clk_en);
    reg_wr = 1; reg_addr = 4'd4; reg_wdata = 2;
    @(posedge clk); @(negedge clk); reg_wr = 0;
    n = 1;
    while (!cpu_clk_en) begin @(negedge clk); n++; end
    chk("R7 old period completes", n, 4);
    n = 0;
    do begin @(negedge clk); n++; end while (!cpu_clk_en);
    chk("R7 new period", n, 2);

    // R10 bus clock
    gap(1, n); chk("R10 bus gap", n, 2);
    count(1, 20, n); chk("R10 bus count", n, 10);

    // R8 slow clock
    wr(4'd5, 3); gap(2, n); gap(2, n); chk("R8 slow div3", n, 6);
    wr(4'd5, 0); count(2, 50, n); chk("R8 slow off", n, 0);

    // R9 reload
    wr(4'd5, 5);
    n = 1;
    while (!slow_clk_en) begin @(negedge clk); n++; end
    chk("R9 first pulse", n, 10);
    repeat (3) @(negedge clk);
    wr(4'd5, 5);
    n = 1;
    while (!slow_clk_en) begin @(negedge clk); n++; end
    chk("R9 rewrite restarts", n, 10);

    // R11 heavy sleep
    wr(4'd6, 3);
    count(0, 20, n); chk("R11 cpu stopped", n, 0);
    count(1, 20, n); chk("R11 bus stopped", n, 0);
    count(2, 20, n); chk("R11 slow runs", n, 2);
    chk("R11 periph unaffected", periph_clk_en, {NPER{1'b1}});
    wr(4'd6, 1); count(0, 20, n); chk("R11 sleep-all alone", n, 10);
    wr(4'd6, 2); count(1, 20, n); chk("R11 heavy alone", n, 10);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule